// File: doc/BRIEF.md
# Priority interrupt claim arbiter

This block arbitrates the external interrupts of one target context. For every source it holds a pending flag, an in-service (claimed) flag, an enable flag and a small priority value. A single threshold applies to the target. The interrupt line to the target is high whenever some source can be taken. A source can be taken when it is pending, not in service, enabled, and has a priority strictly above the threshold.

Software uses a single access port with a valid/ready handshake. One operation is accepted per cycle. An operation writes a priority, an enable word or the threshold, claims the best source, or completes a source. A claim hands back the ID of the selected source one cycle after it is accepted. ID 0 means that no source could be taken. Sources raise requests through one-cycle pulses.

Top module: `prio_irq_arb`

## Requirements
- R1: After reset, every pending, claimed and enable flag is clear, every priority and the threshold are 0, `irq_o` is low and `rsp_valid_o` is low.
- R2: A request pulse on source k sets its pending flag only if source k is not in service at that clock edge. A pulse that arrives while k is in service, including in the same cycle as the completion of k, is dropped.
- R3: `irq_o` is high exactly when some source is pending, not in service, enabled, and has a priority strictly greater than the threshold. A priority equal to the threshold never qualifies. The line follows enable, threshold and priority writes from the cycle after the write is accepted.
- R4: When a claim is accepted, `rsp_valid_o` is high for one cycle in the following cycle. `rsp_id_o` then carries the qualifying source with the largest priority.
- R5: When several qualifying sources share the largest priority, the claim returns the lowest ID among them.
- R6: A claim that finds no qualifying source returns ID 0 and changes no flag. A source that was held back by the threshold stays pending.
- R7: A successful claim clears the winner's pending flag and sets its claimed flag at the same edge. A request pulse for the winner in the claim cycle is absorbed and leaves it not pending.
- R8: A complete operation clears the claimed flag of the source it names. A complete for a source that is not in service changes nothing.
- R9: A pending source whose priority is raised above the threshold asserts `irq_o` and can be claimed. The request is not lost.
- R10: Operation codes on `acc_op_i` are: 0 write priority (ID in `acc_id_i`, value in `acc_wdata_i[2:0]`); 1 write enable word (word index in `acc_id_i`, where bit b of the word is source word*32+b); 2 write threshold (`acc_wdata_i[2:0]`); 3 claim; 4 complete (ID in `acc_id_i`). Writes that name ID 0 or a word index with no sources are ignored.
- R11: `acc_ready_o` is low in reset and high from the second clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_req_i | input | 31 | Request pulses, bit k for source ID k (1..31) |
| acc_valid_i | input | 1 | Operation offered |
| acc_ready_o | output | 1 | Operation can be accepted |
| acc_op_i | input | 3 | Operation code |
| acc_id_i | input | 5 | Source ID or enable word index |
| acc_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Claim result valid |
| rsp_id_o | output | 5 | Claimed source ID, 0 when nothing qualified |
| irq_o | output | 1 | External interrupt request to the target |

## Verification
Two pairs of events can land in the same cycle: a request pulse with a claim, and a request pulse with a complete. The bench drives a request for a source in the very cycle that source is completed, and expects the pulse to be dropped. A later claim must therefore return 0. It also drives a request for the winning source in its own claim cycle, and a request for another source during a claim that finds nothing. The first must leave no pending flag behind. The second must show up only at the next claim, because a claim judges the flags as they stood before the edge.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int unsigned WORD_BITS = 32;

  typedef enum logic [2:0] {
    OP_PRIO     = 3'd0,
    OP_ENABLE   = 3'd1,
    OP_THRESH   = 3'd2,
    OP_CLAIM    = 3'd3,
    OP_COMPLETE = 3'd4
  } acc_op_e;
endpackage

// File: rtl/prio_irq_src.sv
module prio_irq_src #(
  parameter int unsigned PRIO_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              prio_we_i,
  input  logic [PRIO_W-1:0] prio_i,
  input  logic              en_we_i,
  input  logic              en_i,
  input  logic              take_i,
  input  logic              release_i,
  output logic              pending_o,
  output logic              claimed_o,
  output logic              enable_o,
  output logic [PRIO_W-1:0] prio_o
);
  logic              pend_q, clm_q, en_q;
  logic [PRIO_W-1:0] prio_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      clm_q  <= 1'b0;
      en_q   <= 1'b0;
      prio_q <= '0;
    end else begin
      // a claim wins over a same-cycle request for the winner
      if (take_i)                 pend_q <= 1'b0;
      else if (req_i && !clm_q)   pend_q <= 1'b1;
      if (take_i)                 clm_q  <= 1'b1;
      else if (release_i)         clm_q  <= 1'b0;
      if (en_we_i)                en_q   <= en_i;
      if (prio_we_i)              prio_q <= prio_i;
    end
  end

  assign pending_o = pend_q;
  assign claimed_o = clm_q;
  assign enable_o  = en_q;
  assign prio_o    = prio_q;
endmodule

// File: rtl/prio_irq_pick.sv
module prio_irq_pick #(
  parameter int unsigned NUM_SRC = 31,
  parameter int unsigned PRIO_W  = 3,
  parameter int unsigned ID_W    = 5
) (
  input  logic [NUM_SRC:1]             cand_i,
  input  logic [NUM_SRC:1][PRIO_W-1:0] prio_i,
  input  logic [PRIO_W-1:0]            thresh_i,
  output logic [ID_W-1:0]              win_id_o,
  output logic                         win_hit_o
);
  logic [PRIO_W-1:0] best;

  // ascending scan, strict compare: ties keep the lower ID
  always_comb begin
    best     = thresh_i;
    win_id_o = '0;
    for (int i = 1; i <= int'(NUM_SRC); i++) begin
      if (cand_i[i] && (prio_i[i] > best)) begin
        best     = prio_i[i];
        win_id_o = ID_W'(i);
      end
    end
    win_hit_o = (win_id_o != '0);
  end
endmodule

// File: rtl/prio_irq_arb.sv
module prio_irq_arb
  import prio_irq_pkg::*;
#(
  parameter int unsigned NUM_SRC = 31,
  parameter int unsigned PRIO_W  = 3,
  localparam int unsigned ID_W   = $clog2(NUM_SRC + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_SRC:1]     src_req_i,
  input  logic                 acc_valid_i,
  output logic                 acc_ready_o,
  input  logic [2:0]           acc_op_i,
  input  logic [ID_W-1:0]      acc_id_i,
  input  logic [WORD_BITS-1:0] acc_wdata_i,
  output logic                 rsp_valid_o,
  output logic [ID_W-1:0]      rsp_id_o,
  output logic                 irq_o
);
  logic                         ready_q;
  logic                         fire, claim_fire;
  acc_op_e                      op;
  logic [PRIO_W-1:0]            thresh_q;
  logic [NUM_SRC:1]             pend_v, clm_v, en_v, cand_v, hot_v;
  logic [NUM_SRC:1][PRIO_W-1:0] prio_v;
  logic [ID_W-1:0]              win_id;
  logic                         win_hit;
  logic                         rsp_valid_q;
  logic [ID_W-1:0]              rsp_id_q;

  assign op         = acc_op_e'(acc_op_i);
  assign fire       = acc_valid_i && acc_ready_o;
  assign claim_fire = fire && (op == OP_CLAIM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q     <= 1'b0;
      thresh_q    <= '0;
      rsp_valid_q <= 1'b0;
      rsp_id_q    <= '0;
    end else begin
      ready_q     <= 1'b1;
      rsp_valid_q <= claim_fire;
      if (claim_fire)                  rsp_id_q <= win_id;
      if (fire && (op == OP_THRESH))   thresh_q <= acc_wdata_i[PRIO_W-1:0];
    end
  end

  for (genvar i = 1; i <= NUM_SRC; i++) begin : g_src
    localparam int unsigned WIDX = i / WORD_BITS;
    localparam int unsigned BIDX = i % WORD_BITS;

    prio_irq_src #(.PRIO_W(PRIO_W)) u_src (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .req_i     (src_req_i[i]),
      .prio_we_i (fire && (op == OP_PRIO) && (acc_id_i == ID_W'(i))),
      .prio_i    (acc_wdata_i[PRIO_W-1:0]),
      .en_we_i   (fire && (op == OP_ENABLE) && (acc_id_i == ID_W'(WIDX))),
      .en_i      (acc_wdata_i[BIDX]),
      .take_i    (claim_fire && win_hit && (win_id == ID_W'(i))),
      .release_i (fire && (op == OP_COMPLETE) && (acc_id_i == ID_W'(i))),
      .pending_o (pend_v[i]),
      .claimed_o (clm_v[i]),
      .enable_o  (en_v[i]),
      .prio_o    (prio_v[i])
    );

    assign cand_v[i] = pend_v[i] && !clm_v[i] && en_v[i];
    assign hot_v[i]  = cand_v[i] && (prio_v[i] > thresh_q);
  end

  prio_irq_pick #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_pick (
    .cand_i    (cand_v),
    .prio_i    (prio_v),
    .thresh_i  (thresh_q),
    .win_id_o  (win_id),
    .win_hit_o (win_hit)
  );

  assign acc_ready_o = ready_q;
  assign rsp_valid_o = rsp_valid_q;
  assign rsp_id_o    = rsp_id_q;
  assign irq_o       = |hot_v;
endmodule

// File: rtl/prio_irq_arb_chk.sv
module prio_irq_arb_chk
  import prio_irq_pkg::*;
#(
  parameter int unsigned NUM_SRC = 31,
  parameter int unsigned ID_W    = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             acc_valid_i,
  input logic             acc_ready_o,
  input logic [2:0]       acc_op_i,
  input logic             rsp_valid_o,
  input logic [ID_W-1:0]  rsp_id_o,
  input logic             irq_o,
  input logic [NUM_SRC:1] pend_v,
  input logic [NUM_SRC:1] clm_v,
  input logic [NUM_SRC:1] en_v
);
  assert_no_pend_in_service_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_v & clm_v) == '0);

  assert_irq_has_source_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((pend_v & ~clm_v & en_v) != '0));

  assert_rsp_follows_claim_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(acc_valid_i && acc_ready_o && (acc_op_i == 3'(OP_CLAIM))));

  assert_empty_claim_keeps_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && (rsp_id_o == '0)) |-> (clm_v == $past(clm_v)));

  assert_winner_marked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && (rsp_id_o != '0)) |-> (clm_v[rsp_id_o] && !pend_v[rsp_id_o]));

  assert_ready_up_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> acc_ready_o);
endmodule

bind prio_irq_arb prio_irq_arb_chk #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .acc_valid_i (acc_valid_i),
  .acc_ready_o (acc_ready_o),
  .acc_op_i    (acc_op_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_id_o    (rsp_id_o),
  .irq_o       (irq_o),
  .pend_v      (pend_v),
  .clm_v       (clm_v),
  .en_v        (en_v)
);

// File: tb/prio_irq_arb_tb_top.sv
module prio_irq_arb_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] C_PRIO = 3'd0, C_EN = 3'd1, C_THR = 3'd2, C_CLAIM = 3'd3, C_DONE = 3'd4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:1] src_req = '0;
  logic        acc_valid = 1'b0;
  logic        acc_ready;
  logic [2:0]  acc_op = '0;
  logic [4:0]  acc_id = '0;
  logic [31:0] acc_wdata = '0;
  logic        rsp_valid;
  logic [4:0]  rsp_id;
  logic        irq;

  int total = 0, bad = 0;
  bit done = 1'b0;
  int    exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_irq_arb dut_i (
    .clk_i(clk), .rst_ni(rst_n), .src_req_i(src_req),
    .acc_valid_i(acc_valid), .acc_ready_o(acc_ready), .acc_op_i(acc_op),
    .acc_id_i(acc_id), .acc_wdata_i(acc_wdata),
    .rsp_valid_o(rsp_valid), .rsp_id_o(rsp_id), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic acc(input logic [2:0] op, input int id, input int data, input logic [31:1] req);
    @(negedge clk);
    acc_valid = 1'b1; acc_op = op; acc_id = id[4:0]; acc_wdata = data; src_req = req;
    @(negedge clk);
    acc_valid = 1'b0; src_req = '0;
  endtask

  task automatic pulse(input logic [31:1] mask);
    @(negedge clk); src_req = mask;
    @(negedge clk); src_req = '0;
  endtask

  task automatic claim(input int exp, input string tag, input logic [31:1] req = '0);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    acc(C_CLAIM, 0, 0, req);
  endtask

  task automatic irq_is(input bit exp, input string tag);
    chk(irq == exp, tag, int'(irq), int'(exp));
  endtask

  function automatic logic [31:1] bit_of(input int id);
    logic [31:1] m = '0;
    m[id] = 1'b1;
    return m;
  endfunction

  // monitor: compare each claim result with the scoreboard
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4 unexpected response", int'(rsp_id), -1);
      end else begin
        automatic int    e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(int'(rsp_id) == e, t, int'(rsp_id), e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R4 watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(irq == 1'b0, "R1 irq in reset", int'(irq), 0);
    chk(rsp_valid == 1'b0, "R1 rsp_valid in reset", int'(rsp_valid), 0);
    chk(acc_ready == 1'b0, "R11 ready in reset", int'(acc_ready), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(acc_ready == 1'b1, "R11 ready after reset", int'(acc_ready), 1);

    claim(0, "R6 empty claim after reset");

    acc(C_EN, 0, 32'hFFFF_FFFF, '0);
    acc(C_PRIO, 5, 3, '0);
    acc(C_PRIO, 9, 5, '0);
    irq_is(1'b0, "R3 nothing pending");
    pulse(bit_of(5) | bit_of(9));
    irq_is(1'b1, "R3 pending above threshold");
    claim(9, "R4 highest priority first");
    claim(5, "R4 next priority");
    irq_is(1'b0, "R7 both in service");
    claim(0, "R6 all in service");

    pulse(bit_of(5));
    acc(C_DONE, 5, 0, '0);
    irq_is(1'b0, "R2 request while claimed dropped");
    claim(0, "R2 dropped request not pending");
    acc(C_DONE, 9, 0, '0);

    acc(C_PRIO, 12, 2, '0);
    pulse(bit_of(12));
    acc(C_DONE, 12, 0, '0);
    irq_is(1'b1, "R8 complete of unclaimed ignored");
    claim(12, "R8 pending survives stray complete");
    acc(C_DONE, 12, 0, '0);

    acc(C_PRIO, 3, 4, '0);
    acc(C_PRIO, 7, 4, '0);
    acc(C_PRIO, 20, 4, '0);
    pulse(bit_of(3) | bit_of(7) | bit_of(20));
    claim(3, "R5 tie lowest id");
    claim(7, "R5 tie second");
    claim(20, "R5 tie third");
    acc(C_DONE, 3, 0, '0);
    acc(C_DONE, 7, 0, '0);
    acc(C_DONE, 20, 0, '0);

    acc(C_THR, 0, 4, '0);
    pulse(bit_of(3));
    irq_is(1'b0, "R3 priority equal threshold");
    claim(0, "R6 held back by threshold");
    acc(C_THR, 0, 3, '0);
    irq_is(1'b1, "R6 still pending after empty claim");
    claim(3, "R6 held source later claimed");
    acc(C_DONE, 3, 0, '0);
    acc(C_THR, 0, 0, '0);

    pulse(bit_of(25));
    irq_is(1'b0, "R9 priority zero masked");
    acc(C_PRIO, 25, 6, '0);
    irq_is(1'b1, "R9 raised priority asserts irq");
    claim(25, "R9 raised source claimed");

    acc(C_DONE, 25, 0, bit_of(25));
    irq_is(1'b0, "R2 request with own complete dropped");
    claim(0, "R2 no pending after complete+request");

    acc(C_PRIO, 30, 1, '0);
    claim(0, "R2 request during empty claim not seen", bit_of(30));
    irq_is(1'b1, "R2 request during claim pends");
    claim(30, "R2 source pended during claim");
    acc(C_DONE, 30, 0, '0);

    pulse(bit_of(5));
    claim(5, "R7 claim with own request", bit_of(5));
    acc(C_DONE, 5, 0, '0);
    irq_is(1'b0, "R7 request absorbed by claim");
    claim(0, "R7 no leftover pending");

    pulse(bit_of(9));
    irq_is(1'b1, "R3 enabled pending");
    acc(C_EN, 0, 32'h0, '0);
    irq_is(1'b0, "R3 disable drops irq");
    acc(C_EN, 1, 32'hFFFF_FFFF, '0);
    irq_is(1'b0, "R10 write to empty word ignored");
    acc(C_EN, 0, 32'h0000_0200, '0);
    irq_is(1'b1, "R10 enable bit 9 maps to id 9");
    acc(C_PRIO, 0, 7, '0);
    claim(9, "R10 id0 priority write ignored");
    acc(C_DONE, 9, 0, '0);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R4 all claims answered", exp_q.size(), 0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule